// File: doc/BRIEF.md
# Serial Port Interrupt Enable, Mask and Status Unit

This block collects interrupt events for a serial port and turns them into one level interrupt. Software never writes the mask directly. It sets mask bits through a set-only enable register and clears them through a clear-only disable register. An event pulse is latched into a sticky status register only while its mask bit is set. Software clears status bits by writing ones. A separate raw view shows the live FIFO and receiver conditions at all times, whatever the mask holds.

All register images share one bit layout:

| Bit | Meaning |
|-----|---------|
| 0 | receive trigger |
| 1 | receive empty |
| 2 | receive full |
| 3 | transmit empty |
| 4 | transmit full |
| 5 | overrun |
| 6 | framing error |
| 7 | parity error |
| 8 | receive timeout |

The register width is 13 bits. Bits 9 to 12 of the mask can be stored, but no event feeds them.

Writes use one shared data word and one strobe per writable register, so several registers can be written in the same cycle. Reads are combinational and chosen by a selector. The block has no data stream, so there is no valid/ready handshake and nothing is back-pressured.

Top module: `irq_ctrl_unit`

## Requirements
- R1: After reset, the mask and status registers read zero and `irq` is low.
- R2: A write with `wr_stb[0]` sets each mask bit where `wr_data` holds a one. Mask bits where `wr_data` holds a zero keep their value. The new mask is visible after the clock edge.
- R3: A write with `wr_stb[1]` clears each mask bit where `wr_data` holds a one. When `wr_stb[0]` and `wr_stb[1]` write the same bit in the same cycle, that mask bit ends up cleared.
- R4: Reading the enable register (`rd_sel`=0) or the disable register (`rd_sel`=1) returns zero.
- R5: A one on `evt_pulse[i]` sets status bit i at the clock edge only if mask bit i is set before that edge. A masked event leaves no trace in the status register.
- R6: A write with `wr_stb[2]` clears each status bit where `wr_data` holds a one. If an unmasked event for the same bit arrives in the same cycle, the bit ends up set.
- R7: `irq` is a registered signal. It goes high one cycle after a status bit and its mask bit are both set. It goes low one cycle after no such bit remains.
- R8: The raw view (`rd_sel`=4) returns `live_cond` in bits 8:0 in every cycle, whatever the mask holds.
- R9: `wr_data` bits at or above bit 13 have no effect on any register. Read bits at or above bit 13 are always zero. Selector values 5 to 7 read zero.
- R10: A status bit stays set after its event pulse ends, and it stays set when its mask bit is later cleared, until software clears it.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| wr_stb | input | 3 | Write strobes: bit 0 enable (set mask), bit 1 disable (clear mask), bit 2 status clear |
| wr_data | input | 32 | Shared write data word |
| evt_pulse | input | 9 | Event pulses, one per bit of the layout |
| live_cond | input | 9 | Live level conditions, shown in the raw view |
| rd_sel | input | 3 | Read select: 0 enable, 1 disable, 2 mask, 3 status, 4 raw view |
| rd_data | output | 32 | Combinational read data |
| irq | output | 1 | Registered level interrupt |

## Verification
The bench builds the block with its default parameters: 9 event sources, a 13-bit register image and a 32-bit bus. This setting puts three edge cases within reach:
- mask bits 9 to 12 that store values but never see an event;
- a full 32-bit write whose upper 19 bits must vanish;
- enable, disable and status-clear strobes landing in the same cycle as events.

The stimulus table carries mask and status through a fixed sequence, including set-beats-clear and disable-beats-enable collisions. Directed tests then time the interrupt edge, read the write-only registers and compare the raw view against a cleared mask.

// File: rtl/irq_unit_pkg.sv
package irq_unit_pkg;
  localparam int unsigned DEF_NUM_EVT = 9;
  localparam int unsigned DEF_REG_W   = 13;
  localparam int unsigned DEF_BUS_W   = 32;

  localparam int unsigned STB_ENA = 0;
  localparam int unsigned STB_DIS = 1;
  localparam int unsigned STB_CLR = 2;
  localparam int unsigned NUM_STB = 3;

  typedef enum logic [2:0] {
    SEL_ENA  = 3'd0,
    SEL_DIS  = 3'd1,
    SEL_MASK = 3'd2,
    SEL_STAT = 3'd3,
    SEL_RAW  = 3'd4
  } rd_sel_e;
endpackage

// File: rtl/irq_mask_reg.sv
module irq_mask_reg #(
  parameter int unsigned REG_W = 13
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [REG_W-1:0] set_vec,
  input  logic [REG_W-1:0] clr_vec,
  output logic [REG_W-1:0] mask_q
);
  // Clear wins over set for the same bit.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) mask_q <= '0;
    else        mask_q <= (mask_q | set_vec) & ~clr_vec;
  end

  // R2: set bits that are not cleared become visible after the edge.
  assert_mask_set_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (|(set_vec & ~clr_vec)) |=> ((mask_q & $past(set_vec & ~clr_vec)) == $past(set_vec & ~clr_vec)));

  // R3: cleared bits are zero after the edge, even if set in the same cycle.
  assert_mask_clr_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (|clr_vec) |=> ((mask_q & $past(clr_vec)) == '0));

  // R2: bits untouched by either vector keep their value.
  assert_mask_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> (((mask_q ^ $past(mask_q)) & ~$past(set_vec | clr_vec)) == '0));
endmodule

// File: rtl/irq_status_reg.sv
module irq_status_reg #(
  parameter int unsigned NUM_EVT = 9,
  parameter int unsigned REG_W   = 13
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [NUM_EVT-1:0] evt_pulse,
  input  logic [REG_W-1:0]   mask,
  input  logic [REG_W-1:0]   clr_vec,
  output logic [REG_W-1:0]   sts_q
);
  localparam logic [REG_W-1:0] LIVE_BITS = REG_W'((64'd1 << NUM_EVT) - 64'd1);

  logic [REG_W-1:0] evt_ext;
  logic [REG_W-1:0] hit;

  always_comb begin
    evt_ext = '0;
    evt_ext[NUM_EVT-1:0] = evt_pulse;
    hit = evt_ext & mask & LIVE_BITS;
  end

  // A set from an unmasked event wins over a same-cycle clear.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sts_q <= '0;
    else        sts_q <= (sts_q & ~clr_vec) | hit;
  end

  // R5: a newly set status bit had its mask bit set before the edge.
  assert_gate_R5: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> ((sts_q & ~$past(sts_q) & ~$past(mask)) == '0));

  // R6: set has priority over clear.
  assert_set_wins_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (|hit) |=> ((sts_q & $past(hit)) == $past(hit)));

  // R6: a clear with no competing event empties the bit.
  assert_clear_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (|(clr_vec & ~hit)) |=> ((sts_q & $past(clr_vec & ~hit)) == '0));

  // R10: a set bit stays set unless it is cleared.
  assert_sticky_R10: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> ((($past(sts_q) & ~$past(clr_vec)) & ~sts_q) == '0));
endmodule

// File: rtl/irq_read_mux.sv
module irq_read_mux
  import irq_unit_pkg::*;
#(
  parameter int unsigned NUM_EVT = 9,
  parameter int unsigned REG_W   = 13,
  parameter int unsigned BUS_W   = 32
) (
  input  logic [2:0]         rd_sel,
  input  logic [REG_W-1:0]   mask,
  input  logic [REG_W-1:0]   sts,
  input  logic [NUM_EVT-1:0] live_cond,
  output logic [BUS_W-1:0]   rd_data
);
  logic [REG_W-1:0] img;

  always_comb begin
    img = '0;
    case (rd_sel_e'(rd_sel))
      SEL_MASK: img = mask;
      SEL_STAT: img = sts;
      SEL_RAW:  img[NUM_EVT-1:0] = live_cond;
      default:  img = '0;   // enable, disable and unused selectors
    endcase
    rd_data = '0;
    rd_data[REG_W-1:0] = img;
  end
endmodule

// File: rtl/irq_ctrl_unit.sv
module irq_ctrl_unit
  import irq_unit_pkg::*;
#(
  parameter int unsigned NUM_EVT = DEF_NUM_EVT,
  parameter int unsigned REG_W   = DEF_REG_W,
  parameter int unsigned BUS_W   = DEF_BUS_W
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [NUM_STB-1:0] wr_stb,
  input  logic [BUS_W-1:0]   wr_data,
  input  logic [NUM_EVT-1:0] evt_pulse,
  input  logic [NUM_EVT-1:0] live_cond,
  input  logic [2:0]         rd_sel,
  output logic [BUS_W-1:0]   rd_data,
  output logic               irq
);
  logic [REG_W-1:0] wr_img;
  logic [REG_W-1:0] set_vec, dis_vec, clr_vec;
  logic [REG_W-1:0] mask_q, sts_q;
  logic             irq_q;

  // Upper write bits are dropped here.
  assign wr_img  = wr_data[REG_W-1:0];
  assign set_vec = wr_stb[STB_ENA] ? wr_img : '0;
  assign dis_vec = wr_stb[STB_DIS] ? wr_img : '0;
  assign clr_vec = wr_stb[STB_CLR] ? wr_img : '0;

  irq_mask_reg #(.REG_W(REG_W)) u_mask (
    .clk     (clk),
    .rst_n   (rst_n),
    .set_vec (set_vec),
    .clr_vec (dis_vec),
    .mask_q  (mask_q)
  );

  irq_status_reg #(.NUM_EVT(NUM_EVT), .REG_W(REG_W)) u_status (
    .clk       (clk),
    .rst_n     (rst_n),
    .evt_pulse (evt_pulse),
    .mask      (mask_q),
    .clr_vec   (clr_vec),
    .sts_q     (sts_q)
  );

  irq_read_mux #(.NUM_EVT(NUM_EVT), .REG_W(REG_W), .BUS_W(BUS_W)) u_rd (
    .rd_sel    (rd_sel),
    .mask      (mask_q),
    .sts       (sts_q),
    .live_cond (live_cond),
    .rd_data   (rd_data)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) irq_q <= 1'b0;
    else        irq_q <= |(sts_q & mask_q);
  end
  assign irq = irq_q;

  // R7: irq rises only after an enabled status bit was present.
  assert_irq_rise_R7: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(irq_q) |-> $past(|(sts_q & mask_q)));

  // R7: irq falls only after no enabled status bit remained.
  assert_irq_fall_R7: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(irq_q) |-> !$past(|(sts_q & mask_q)));

  // R9: read bits above the register image are zero.
  assert_rd_upper_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_data >> REG_W) == '0);
endmodule

// File: tb/tb_irq_ctrl_unit.sv
module tb_irq_ctrl_unit;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [2:0]  wr_stb = '0;
  logic [31:0] wr_data = '0;
  logic [8:0]  evt_pulse = '0;
  logic [8:0]  live_cond = '0;
  logic [2:0]  rd_sel = '0;
  logic [31:0] rd_data;
  logic        irq;

  int checks = 0;
  int fails  = 0;
  bit done   = 0;

  always #10 clk = ~clk;   // 50 MHz

  irq_ctrl_unit dut (
    .clk(clk), .rst_n(rst_n), .wr_stb(wr_stb), .wr_data(wr_data),
    .evt_pulse(evt_pulse), .live_cond(live_cond), .rd_sel(rd_sel),
    .rd_data(rd_data), .irq(irq)
  );

  // Vector fields: {stb, wdata, evt, expected mask, expected status}.
  localparam int NV = 11;
  localparam logic [69:0] VEC [NV] = '{
    {3'b001, 32'h0000_0009, 9'h000, 13'h0009, 13'h0000}, // R2 set bits 0,3
    {3'b001, 32'h0000_0100, 9'h000, 13'h0109, 13'h0000}, // R2 zeros keep bits
    {3'b000, 32'h0000_0000, 9'h1FF, 13'h0109, 13'h0109}, // R5 gated capture
    {3'b100, 32'h0000_0001, 9'h000, 13'h0109, 13'h0108}, // R6 clear bit 0
    {3'b010, 32'h0000_0008, 9'h000, 13'h0101, 13'h0108}, // R3 disable, R10 sticky
    {3'b011, 32'h0000_0100, 9'h000, 13'h0001, 13'h0108}, // R3 both strobes -> clear
    {3'b100, 32'h0000_0108, 9'h008, 13'h0001, 13'h0000}, // R6 clear, R5 masked evt
    {3'b100, 32'h0000_0001, 9'h001, 13'h0001, 13'h0001}, // R6 set wins
    {3'b001, 32'hFFFF_FFFF, 9'h000, 13'h1FFF, 13'h0001}, // R9 upper write ignored
    {3'b010, 32'hFFFF_FFFF, 9'h000, 13'h0000, 13'h0001}, // R3 full disable, R10
    {3'b100, 32'hFFFF_FFFF, 9'h000, 13'h0000, 13'h0000}  // R6 full clear
  };

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic rd(input logic [2:0] sel, output logic [31:0] val);
    rd_sel = sel;
    #1;
    val = rd_data;
  endtask

  // Drive at negedge, release just after posedge, return at next negedge.
  task automatic cyc(input logic [2:0] stb, input logic [31:0] d, input logic [8:0] ev);
    @(negedge clk);
    wr_stb = stb; wr_data = d; evt_pulse = ev;
    @(posedge clk);
    #1;
    wr_stb = '0; wr_data = '0; evt_pulse = '0;
    @(negedge clk);
  endtask

  initial begin
    #(20 * 200000);
    if (!done) begin
      fails++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    logic [31:0] v;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    rd(3'd2, v); chk("R1 mask after reset", v, 32'h0);
    rd(3'd3, v); chk("R1 status after reset", v, 32'h0);
    chk("R1 irq after reset", {31'h0, irq}, 32'h0);

    for (int i = 0; i < NV; i++) begin
      cyc(VEC[i][69:67], VEC[i][66:35], VEC[i][34:26]);
      rd(3'd2, v); chk($sformatf("R2/R3/R9 mask vec %0d", i), v, {19'h0, VEC[i][25:13]});
      rd(3'd3, v); chk($sformatf("R5/R6/R10 status vec %0d", i), v, {19'h0, VEC[i][12:0]});
    end

    // R7 irq timing: mask and status are zero here
    cyc(3'b001, 32'h1, 9'h000);   // enable bit 0
    cyc(3'b000, 32'h0, 9'h001);   // event captured at this edge
    chk("R7 irq one cycle after status", {31'h0, irq}, 32'h0);
    @(negedge clk);
    chk("R7 irq high", {31'h0, irq}, 32'h1);
    cyc(3'b010, 32'h1, 9'h000);   // disable bit 0
    @(negedge clk);
    chk("R7 irq low after disable", {31'h0, irq}, 32'h0);
    rd(3'd3, v); chk("R10 status kept after mask cleared", v, 32'h1);

    // R4 write-only registers read zero
    cyc(3'b001, 32'h1FFF, 9'h000);
    rd(3'd0, v); chk("R4 enable reads zero", v, 32'h0);
    rd(3'd1, v); chk("R4 disable reads zero", v, 32'h0);
    rd(3'd5, v); chk("R9 unused selector zero", v, 32'h0);
    rd(3'd2, v); chk("R9 mask upper bits zero", v, 32'h1FFF);

    // R8 raw view regardless of mask
    cyc(3'b110, 32'hFFFF_FFFF, 9'h000);
    live_cond = 9'h01E;
    rd(3'd4, v); chk("R8 raw view with mask clear", v, 32'h01E);
    rd(3'd3, v); chk("R8 status untouched by levels", v, 32'h0);
    live_cond = 9'h1A5;
    rd(3'd4, v); chk("R8 raw view follows input", v, 32'h1A5);

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule